// File: doc/BRIEF.md
# Status Register Write-Protect Unit

This unit sits beside the command decoder of a serial byte-addressed memory slave. It holds the eight-bit status byte: a status-lock enable, three spare bits, a two-bit protected-range selector, the write-enable flag and a constant zero. It decides, cycle by cycle, whether the array byte presented by the decoder may be stored and whether a status update may be applied.

The decoder sends it single-cycle strobes. These mark a write-enable command, a write-disable command, the recognition of a status-write or array-write opcode, the status data byte, each array data byte with its address, and the chip-select rising edge. The unit also sees the external active-low lock pin. The stored bits other than the write-enable flag stand in for nonvolatile cells. Only reset reloads them, from a parameter.

Top module: `sr_guard`

## Requirements
- R1: `status_q` is laid out as bit 7 lock enable, bits 6..4 spare, bits 3..2 range selector, bit 1 write-enable flag, bit 0 always 0. After reset, bits 7..2 equal `NV_INIT` and bit 1 is 0.
- R2: A `wren_stb` sets the write-enable flag and a `wrdi_stb` clears it. Each change is visible on `status_q` at the next rising clock edge.
- R3: An allowed status write (`sr_data_vld` with `sr_allow` high) copies `sr_data[7:2]` into `status_q[7:2]` at the next edge. `sr_data[1:0]` is ignored, so the flag and bit 0 keep their values.
- R4: A `cs_rise` clears the write-enable flag at the next edge if a status-write or array-write opcode was recognised since the previous `cs_rise`. This holds whether or not the write itself was allowed.
- R5: A `cs_rise` with no recognised write opcode since the previous one leaves the flag unchanged. This covers a command aborted during a hold.
- R6: While the flag is 0, `arr_we` and `sr_allow` are 0 and a status data byte changes nothing.
- R7: `arr_we` is high in the same cycle as `arr_byte_vld` only when the flag is 1 and the address is outside the protected range. Selector 00 protects nothing, 01 protects addresses 0x1800..0x1FFF, 10 protects 0x1000..0x1FFF, and 11 protects every address (13-bit address).
- R8: `sr_allow` is 1 when the flag is 1, unless the lock enable is 1 and the lock pin, sampled when the status-write opcode was recognised, was 0. Later changes of the pin do not affect that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wren_stb | input | 1 | Write-enable command recognised |
| wrdi_stb | input | 1 | Write-disable command recognised |
| sr_op_stb | input | 1 | Status-write opcode recognised; samples lock pin |
| arr_op_stb | input | 1 | Array-write opcode recognised |
| sr_data_vld | input | 1 | Status data byte present |
| sr_data | input | 8 | Status data byte |
| arr_byte_vld | input | 1 | Array data byte present |
| arr_addr | input | ADDR_W | Address of the array byte |
| cs_rise | input | 1 | Chip-select rising edge seen |
| lock_pin_n | input | 1 | Status lock pin, low locks |
| status_q | output | 8 | Status byte for read-back |
| sr_allow | output | 1 | A status write would be applied now |
| arr_we | output | 1 | Array byte may be stored this cycle |

## Verification
The assertions assume that the decoder raises at most one strobe per cycle. They also assume that data strobes follow their opcode strobe within the same chip-select frame, and one assertion states the one-strobe rule. Both the directed sequences and the random phase drive exactly one strobe, or none, each cycle. The random phase still lets the lock pin and the address change freely, so sampled and live pin values diverge. The directed part covers the range boundaries at 0x17FF/0x1800 and 0x0FFF/0x1000, a locked status write, a pin change after the opcode, and a chip-select rise without an opcode.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
  localparam int unsigned SR_W    = 8;
  localparam int unsigned NV_W    = 6;
  localparam int unsigned SPARE_W = 3;

  typedef struct packed {
    logic               lock_en;
    logic [SPARE_W-1:0] spare;
    logic [1:0]         rsel;
  } nv_t;

  typedef enum logic [1:0] {
    RSEL_NONE    = 2'b00,
    RSEL_QUARTER = 2'b01,
    RSEL_HALF    = 2'b10,
    RSEL_ALL     = 2'b11
  } rsel_e;
endpackage

// File: rtl/sr_guard_nv.sv
module sr_guard_nv
  import sr_guard_pkg::*;
#(
  parameter logic [NV_W-1:0] NV_INIT = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NV_W-1:0] wr_bits,
  output nv_t             nv_q
);
  nv_t nv_d;

  always_comb begin
    nv_d = nv_q;
    if (wr_en) nv_d = nv_t'(wr_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     nv_q <= nv_t'(NV_INIT);
    else if (wr_en) nv_q <= nv_d;
  end
endmodule

// File: rtl/sr_guard_wel.sv
module sr_guard_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic wren_stb,
  input  logic wrdi_stb,
  input  logic sr_op_stb,
  input  logic arr_op_stb,
  input  logic cs_rise,
  input  logic lock_pin_n,
  output logic wel_q,
  output logic pend_q,
  output logic pin_s_q
);
  logic wel_d, pend_d, pin_s_d;
  logic wel_en, pend_en;

  always_comb begin
    wel_d = wel_q;
    if (wren_stb)          wel_d = 1'b1;
    if (wrdi_stb)          wel_d = 1'b0;
    if (cs_rise && pend_q) wel_d = 1'b0;
    wel_en = wren_stb | wrdi_stb | (cs_rise & pend_q);

    pend_d = pend_q;
    if (cs_rise)                      pend_d = 1'b0;
    else if (sr_op_stb || arr_op_stb) pend_d = 1'b1;
    pend_en = cs_rise | sr_op_stb | arr_op_stb;

    pin_s_d = lock_pin_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wel_q <= 1'b0;
    else if (wel_en) wel_q <= wel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pin_s_q <= 1'b1;
    else if (sr_op_stb) pin_s_q <= pin_s_d;
  end
endmodule

// File: rtl/sr_guard_prot.sv
module sr_guard_prot
  import sr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic [1:0]        rsel,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] QUARTER_LO = ADDR_W'(3) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] HALF_LO    = ADDR_W'(1) << (ADDR_W - 1);

  logic in_quarter, in_half;

  generate
    if (ADDR_W >= 2) begin : g_cmp
      assign in_quarter = (addr >= QUARTER_LO);
      assign in_half    = (addr >= HALF_LO);
    end else begin : g_tiny
      assign in_quarter = 1'b0;
      assign in_half    = addr[0];
    end
  endgenerate

  always_comb begin
    unique case (rsel_e'(rsel))
      RSEL_NONE:    hit = 1'b0;
      RSEL_QUARTER: hit = in_quarter;
      RSEL_HALF:    hit = in_half;
      RSEL_ALL:     hit = 1'b1;
      default:      hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import sr_guard_pkg::*;
#(
  parameter int unsigned     ADDR_W  = 13,
  parameter logic [NV_W-1:0] NV_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_stb,
  input  logic              wrdi_stb,
  input  logic              sr_op_stb,
  input  logic              arr_op_stb,
  input  logic              sr_data_vld,
  input  logic [7:0]        sr_data,
  input  logic              arr_byte_vld,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              cs_rise,
  input  logic              lock_pin_n,
  output logic [7:0]        status_q,
  output logic              sr_allow,
  output logic              arr_we
);
  nv_t  nv_q;
  logic wel_q, pend_q, pin_s_q;
  logic prot_hit;
  logic nv_wr;
  logic unused_low;

  assign unused_low = ^sr_data[1:0];

  sr_guard_wel u_wel (
    .clk        (clk),
    .rst_n      (rst_n),
    .wren_stb   (wren_stb),
    .wrdi_stb   (wrdi_stb),
    .sr_op_stb  (sr_op_stb),
    .arr_op_stb (arr_op_stb),
    .cs_rise    (cs_rise),
    .lock_pin_n (lock_pin_n),
    .wel_q      (wel_q),
    .pend_q     (pend_q),
    .pin_s_q    (pin_s_q)
  );

  sr_guard_prot #(.ADDR_W(ADDR_W)) u_prot (
    .rsel (nv_q.rsel),
    .addr (arr_addr),
    .hit  (prot_hit)
  );

  assign sr_allow = wel_q & ~(nv_q.lock_en & ~pin_s_q);
  assign nv_wr    = sr_data_vld & sr_allow;

  sr_guard_nv #(.NV_INIT(NV_INIT)) u_nv (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (nv_wr),
    .wr_bits (sr_data[7:2]),
    .nv_q    (nv_q)
  );

  assign arr_we   = arr_byte_vld & wel_q & ~prot_hit;
  assign status_q = {nv_q, wel_q, 1'b0};
endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wren_stb,
  input logic       wrdi_stb,
  input logic       sr_op_stb,
  input logic       arr_op_stb,
  input logic       sr_data_vld,
  input logic       arr_byte_vld,
  input logic       cs_rise,
  input logic       pend_q,
  input logic       pin_s_q,
  input logic [7:0] status_q,
  input logic       arr_we
);
  // R2: input rule, one strobe per cycle at most
  p_one_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wren_stb, wrdi_stb, sr_op_stb, arr_op_stb, sr_data_vld, arr_byte_vld, cs_rise}));

  p_wel_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wren_stb && !wrdi_stb && !(cs_rise && pend_q) |=> status_q[1]);

  p_wel_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrdi_stb |=> !status_q[1]);

  p_cs_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && pend_q |=> !status_q[1]);

  p_cs_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && !pend_q && !wren_stb && !wrdi_stb |=> $stable(status_q[1]));

  p_no_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> status_q[1]);

  p_sr_nowel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sr_data_vld && !status_q[1] |=> $stable(status_q[7:2]));

  p_all_prot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> status_q[3:2] != 2'b11);

  p_we_needs_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> arr_byte_vld);

  p_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_data_vld && status_q[7] && !pin_s_q |=> $stable(status_q[7:2]));
endmodule

bind sr_guard sr_guard_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wren_stb     (wren_stb),
  .wrdi_stb     (wrdi_stb),
  .sr_op_stb    (sr_op_stb),
  .arr_op_stb   (arr_op_stb),
  .sr_data_vld  (sr_data_vld),
  .arr_byte_vld (arr_byte_vld),
  .cs_rise      (cs_rise),
  .pend_q       (pend_q),
  .pin_s_q      (pin_s_q),
  .status_q     (status_q),
  .arr_we       (arr_we)
);

// File: tb/sr_guard_tb_top.sv
module sr_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wren_stb, wrdi_stb, sr_op_stb, arr_op_stb;
  logic          sr_data_vld, arr_byte_vld, cs_rise, lock_pin_n;
  logic [7:0]    sr_data;
  logic [AW-1:0] arr_addr;
  logic [7:0]    status_q;
  logic          sr_allow, arr_we;

  int checks = 0;
  int errors = 0;

  int m_wel, m_pend, m_pin, m_nv;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_guard #(.ADDR_W(AW), .NV_INIT(6'h00)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wren_stb     (wren_stb),
    .wrdi_stb     (wrdi_stb),
    .sr_op_stb    (sr_op_stb),
    .arr_op_stb   (arr_op_stb),
    .sr_data_vld  (sr_data_vld),
    .sr_data      (sr_data),
    .arr_byte_vld (arr_byte_vld),
    .arr_addr     (arr_addr),
    .cs_rise      (cs_rise),
    .lock_pin_n   (lock_pin_n),
    .status_q     (status_q),
    .sr_allow     (sr_allow),
    .arr_we       (arr_we)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int prot(input int rsel, input int addr);
    case (rsel)
      0: return 0;
      1: return (addr >= 32'h1800) ? 1 : 0;
      2: return (addr >= 32'h1000) ? 1 : 0;
      default: return 1;
    endcase
  endfunction

  function automatic int m_sr_ok();
    return (m_wel == 1 && !(((m_nv >> 5) & 1) == 1 && m_pin == 0)) ? 1 : 0;
  endfunction

  // one clock: drive at negedge, check combinational outputs, update model, check status
  task automatic cyc(input string tag, input bit wren, input bit wrdi, input bit sop,
                     input bit aop, input bit sdv, input logic [7:0] sd, input bit bv,
                     input int ad, input bit csr, input bit pin);
    int exp_we, exp_sr;
    wren_stb = wren; wrdi_stb = wrdi; sr_op_stb = sop; arr_op_stb = aop;
    sr_data_vld = sdv; sr_data = sd; arr_byte_vld = bv; arr_addr = AW'(ad);
    cs_rise = csr; lock_pin_n = pin;
    #1;
    exp_sr = m_sr_ok();
    exp_we = (bv && m_wel == 1 && prot(m_nv & 3, ad) == 0) ? 1 : 0;
    chk({tag, " arr_we"}, int'(arr_we), exp_we);
    chk({tag, " sr_allow"}, int'(sr_allow), exp_sr);
    @(posedge clk);
    if (sdv && exp_sr == 1) m_nv = int'(sd[7:2]);
    if (wren) m_wel = 1;
    if (wrdi) m_wel = 0;
    if (csr && m_pend == 1) m_wel = 0;
    if (csr) m_pend = 0;
    else if (sop || aop) m_pend = 1;
    if (sop) m_pin = pin;
    @(negedge clk);
    chk({tag, " status"}, int'(status_q), (m_nv << 2) | (m_wel << 1));
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, 0, 0, 0, 8'h00, 0, 0, 0, 1);
  endtask

  task automatic set_status(input string tag, input logic [7:0] v);
    cyc(tag, 1, 0, 0, 0, 0, 8'h00, 0, 0, 0, 1);
    cyc(tag, 0, 0, 1, 0, 0, 8'h00, 0, 0, 0, 1);
    cyc(tag, 0, 0, 0, 0, 1, v, 0, 0, 0, 1);
    cyc(tag, 0, 0, 0, 0, 0, 8'h00, 0, 0, 1, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wren_stb = 0; wrdi_stb = 0; sr_op_stb = 0; arr_op_stb = 0;
    sr_data_vld = 0; sr_data = 0; arr_byte_vld = 0; arr_addr = 0;
    cs_rise = 0; lock_pin_n = 1;
    m_wel = 0; m_pend = 0; m_pin = 1; m_nv = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset status", int'(status_q), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after release", int'(status_q), 0);

    // R6: flag clear blocks array and status writes
    cyc("R6 blocked byte", 0, 0, 0, 1, 0, 8'h00, 0, 0, 0, 1);
    cyc("R6 blocked byte", 0, 0, 0, 0, 0, 8'h00, 1, 0, 0, 1);
    cyc("R4 cs after blocked write", 0, 0, 0, 0, 0, 8'h00, 0, 0, 1, 1);
    // R2: set and clear of the flag
    cyc("R2 set", 1, 0, 0, 0, 0, 8'h00, 0, 0, 0, 1);
    cyc("R2 clear", 0, 1, 0, 0, 0, 8'h00, 0, 0, 0, 1);
    cyc("R2 set again", 1, 0, 0, 0, 0, 8'h00, 0, 0, 0, 1);
    // R7: selector 00 protects nothing
    cyc("R7 op", 0, 0, 0, 1, 0, 8'h00, 0, 0, 0, 1);
    cyc("R7 none low", 0, 0, 0, 0, 0, 8'h00, 1, 32'h0000, 0, 1);
    cyc("R7 none top", 0, 0, 0, 0, 0, 8'h00, 1, 32'h1FFF, 0, 1);
    cyc("R4 cs clears", 0, 0, 0, 0, 0, 8'h00, 0, 0, 1, 1);
    // R3: status write ignores low two data bits
    set_status("R3 write FF", 8'hFF);
    set_status("R3 write 86", 8'h86);
    // R7: quarter range, lock enabled
    cyc("R7 wren", 1, 0, 0, 0, 0, 8'h00, 0, 0, 0, 1);
    cyc("R7 op", 0, 0, 0, 1, 0, 8'h00, 0, 0, 0, 1);
    cyc("R7 quarter 17FF", 0, 0, 0, 0, 0, 8'h00, 1, 32'h17FF, 0, 1);
    cyc("R7 quarter 1800", 0, 0, 0, 0, 0, 8'h00, 1, 32'h1800, 0, 1);
    cyc("R7 quarter 1FFF", 0, 0, 0, 0, 0, 8'h00, 1, 32'h1FFF, 0, 1);
    cyc("R4 cs after write", 0, 0, 0, 0, 0, 8'h00, 0, 0, 1, 1);
    // R8: locked status write with pin low at opcode
    cyc("R8 wren", 1, 0, 0, 0, 0, 8'h00, 0, 0, 0, 0);
    cyc("R8 op pin low", 0, 0, 1, 0, 0, 8'h00, 0, 0, 0, 0);
    cyc("R8 locked data", 0, 0, 0, 0, 1, 8'h08, 0, 0, 0, 1);
    cyc("R4 cs after locked", 0, 0, 0, 0, 0, 8'h00, 0, 0, 1, 1);
    // R8: pin high at opcode, drops later, write still allowed
    cyc("R8 wren", 1, 0, 0, 0, 0, 8'h00, 0, 0, 0, 1);
    cyc("R8 op pin high", 0, 0, 1, 0, 0, 8'h00, 0, 0, 0, 1);
    cyc("R8 pin drops", 0, 0, 0, 0, 1, 8'h08, 0, 0, 0, 0);
    cyc("R4 cs", 0, 0, 0, 0, 0, 8'h00, 0, 0, 1, 1);
    // R7: half range
    cyc("R7 wren", 1, 0, 0, 0, 0, 8'h00, 0, 0, 0, 1);
    cyc("R7 op", 0, 0, 0, 1, 0, 8'h00, 0, 0, 0, 1);
    cyc("R7 half 0FFF", 0, 0, 0, 0, 0, 8'h00, 1, 32'h0FFF, 0, 1);
    cyc("R7 half 1000", 0, 0, 0, 0, 0, 8'h00, 1, 32'h1000, 0, 1);
    cyc("R4 cs", 0, 0, 0, 0, 0, 8'h00, 0, 0, 1, 1);
    // R5: aborted command, cs rise without opcode keeps flag
    cyc("R5 wren", 1, 0, 0, 0, 0, 8'h00, 0, 0, 0, 1);
    cyc("R5 cs no op", 0, 0, 0, 0, 0, 8'h00, 0, 0, 1, 1);
    idle("R5 flag kept");
    cyc("R5 wrdi", 0, 1, 0, 0, 0, 8'h00, 0, 0, 0, 1);
    // R7: whole array protected
    set_status("R7 set all", 8'h0C);
    cyc("R7 wren", 1, 0, 0, 0, 0, 8'h00, 0, 0, 0, 1);
    cyc("R7 op", 0, 0, 0, 1, 0, 8'h00, 0, 0, 0, 1);
    cyc("R7 all 0000", 0, 0, 0, 0, 0, 8'h00, 1, 32'h0000, 0, 1);
    cyc("R4 cs", 0, 0, 0, 0, 0, 8'h00, 0, 0, 1, 1);
    // R6: status write with flag clear
    cyc("R6 op", 0, 0, 1, 0, 0, 8'h00, 0, 0, 0, 1);
    cyc("R6 data ignored", 0, 0, 0, 0, 1, 8'hF0, 0, 0, 0, 1);
    cyc("R6 cs", 0, 0, 0, 0, 0, 8'h00, 0, 0, 1, 1);

    // mixed one-strobe-per-cycle traffic against the model (R7, R8)
    for (int i = 0; i < 3000; i++) begin
      int k;
      logic [7:0] d;
      int a;
      bit p;
      k = $urandom_range(0, 7);
      d = 8'($urandom);
      a = $urandom_range(0, 8191);
      p = 1'($urandom);
      cyc("R7 R8 mixed", k == 0, k == 1, k == 2, k == 3, k == 4, d, k == 5, a, k == 6, p);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule